// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates among a parameterized set of external interrupt lines and one non-maskable request. It decides which exception the core runs next and reports that exception as a vector number. Every line has four pieces of state: an enable bit, a pending bit, an active bit and an 8-bit priority. A small register port, addressed by a selector and a line index, reaches them. A lower priority number is more urgent. The non-maskable request ranks above every configurable level and cannot be masked.

The controller tracks the current execution level as the most urgent level in the active set. A stack of the exceptions in progress records the nesting order, so an exception-return pulse retires the right one. The time the core spends on state save, tail-chain transfer and state restore is modelled as fixed busy intervals on `core_busy`. A more urgent request that arrives during a save or transfer interval replaces the target without restarting the interval (late arrival). A return that finds an eligible request chains directly into it. The final restore happens only when the last exception goes back to thread level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Enable and pending bits are reached through the register port with write-one masks on `reg_wdata[NUM_LINES-1:0]`. Selector 0 sets enables, 1 clears enables, 2 sets pending, 3 clears pending. Selectors 0 and 1 read the enable vector, 2 and 3 read the pending vector.
- R2: A pending line is taken only when it is enabled and its priority is strictly more urgent than the current execution level. A request of equal level to the running handler waits, and a disabled line stays pending without being taken.
- R3: A line's active bit is set while its handler runs and stays set while a more urgent exception preempts it. The bit is cleared when that handler returns. The active vector reads on selector 5, and writes to selector 5 have no effect.
- R4: Selector 4 writes and reads the 8-bit priority of the line given by `reg_idx`. The value 0 is the most urgent configurable level.
- R5: A pulse on `nmi_req` pends the non-maskable exception whatever the enables are. It is more urgent than every line and preempts any line handler. Selector 6 reads bit 0 as its pending flag and bit 1 as its active flag.
- R6: Taking an exception from thread level, or by preemption, holds `core_busy` high for exactly 12 cycles. After that, `handler_run` rises and `vector` shows the new exception: 0 for thread, 2 for non-maskable, 16+i for line i.
- R7: When `exc_return` retires a handler and an eligible request is pending against the remaining active set, the controller chains into it after a 6-cycle busy interval, with no restore.
- R8: A return that finds nothing eligible resumes the preempted handler at once, with no busy interval, if one remains. If none remains, it performs a 12-cycle restore and then shows vector 0.
- R9: A more urgent eligible request that arrives during a save interval is entered first, and the save interval is not lengthened. The displaced request stays pending and chains in after the first handler returns.
- R10: Among eligible requests of equal priority, the lowest-numbered line is taken first.
- R11: Taking a line clears its pending bit, and a high level on `irq_in[i]` sets pending bit i.
- R12: A pending bit set again while its line is active is held. It is taken after that handler returns, if it is still eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_idx | input | $clog2(NUM_LINES) | Line index for priority access |
| reg_wdata | input | max(NUM_LINES,PRIO_W) | Write data or write-one mask |
| reg_rdata | output | max(NUM_LINES,PRIO_W) | Read data for the selected register |
| irq_in | input | NUM_LINES | Hardware request per line, sets pending |
| nmi_req | input | 1 | Non-maskable request pulse |
| exc_return | input | 1 | Exception-return pulse from the core |
| core_busy | output | 1 | Save, chain or restore interval in progress |
| handler_run | output | 1 | A handler is executing |
| vector | output | $clog2(NUM_LINES+17) | Number of the current exception |

## Verification
The bench builds the block with six lines, 8-bit priorities and the interval lengths 12, 6 and 12. Six lines are enough for three levels of nesting, for a tie between two lines, and for one random request mask to hold every line at once. The random phase draws priorities from a narrow range so that ties and long tail-chain sequences occur often. The 8-bit priority field still lets the directed cases use the most urgent and widely spaced levels.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTRY = 2'd1,
        ST_CHAIN = 2'd2,
        ST_EXIT  = 2'd3
    } ctl_state_e;

    localparam logic [2:0] SEL_EN_SET   = 3'd0;
    localparam logic [2:0] SEL_EN_CLR   = 3'd1;
    localparam logic [2:0] SEL_PEND_SET = 3'd2;
    localparam logic [2:0] SEL_PEND_CLR = 3'd3;
    localparam logic [2:0] SEL_PRIO     = 3'd4;
    localparam logic [2:0] SEL_ACTIVE   = 3'd5;
    localparam logic [2:0] SEL_NMI_STAT = 3'd6;

    localparam int VEC_NMI       = 2;
    localparam int VEC_LINE_BASE = 16;

endpackage

// File: rtl/irq_level_min.sv
module irq_level_min #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 8,
    localparam int KEY_W    = PRIO_W + 2
) (
    input  logic [NUM_LINES-1:0]             act_lines,
    input  logic                             act_nmi,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic [KEY_W-1:0]                 level
);
    localparam logic [KEY_W-1:0] THREAD_KEY = {2'b10, {PRIO_W{1'b0}}};

    // Most urgent level in the active set; thread level when empty.
    always_comb begin
        level = THREAD_KEY;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act_lines[i] && ({2'b01, prio[i]} < level)) begin
                level = {2'b01, prio[i]};
            end
        end
        if (act_nmi) begin
            level = '0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 8,
    localparam int KEY_W    = PRIO_W + 2,
    localparam int IDW      = $clog2(NUM_LINES + 1)
) (
    input  logic [NUM_LINES-1:0]             cand_lines,
    input  logic                             cand_nmi,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic [IDW-1:0]                   best_id,
    output logic [KEY_W-1:0]                 best_key
);
    localparam logic [KEY_W-1:0] THREAD_KEY = {2'b10, {PRIO_W{1'b0}}};

    // Strict compare keeps the lowest index among equal levels.
    always_comb begin
        best_key = THREAD_KEY;
        best_id  = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand_lines[i] && ({2'b01, prio[i]} < best_key)) begin
                best_key = {2'b01, prio[i]};
                best_id  = IDW'(i);
            end
        end
        if (cand_nmi) begin
            best_key = '0;
            best_id  = IDW'(NUM_LINES);
        end
    end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
    parameter int DEPTH = 9,
    parameter int IDW   = 4,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [IDW-1:0] push_id,
    output logic [IDW-1:0] top_id,
    output logic           empty,
    output logic           full
);
    logic [DEPTH-1:0][IDW-1:0] mem_d, mem_q;
    logic [SPW-1:0]            sp_d, sp_q;

    always_comb begin
        mem_d = mem_q;
        sp_d  = sp_q;
        top_id = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SPW'(i + 1)) top_id = mem_q[i];
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (sp_q == SPW'(i)) mem_d[i] = push_id;
            end
            sp_d = sp_q + 1'b1;
        end else if (pop) begin
            sp_d = sp_q - 1'b1;
        end
    end

    assign empty = (sp_q == '0);
    assign full  = (sp_q == SPW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            sp_q  <= '0;
        end else begin
            mem_q <= mem_d;
            sp_q  <= sp_d;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int PRIO_W     = 8,
    parameter int ENTRY_CYC  = 12,
    parameter int CHAIN_CYC  = 6,
    parameter int EXIT_CYC   = 12,
    localparam int IDXW      = $clog2(NUM_LINES),
    localparam int DW        = (NUM_LINES > PRIO_W) ? NUM_LINES : PRIO_W,
    localparam int VEC_W     = $clog2(NUM_LINES + 17)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [IDXW-1:0]      reg_idx,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 nmi_req,
    input  logic                 exc_return,
    output logic                 core_busy,
    output logic                 handler_run,
    output logic [VEC_W-1:0]     vector
);
    localparam int KEY_W  = PRIO_W + 2;
    localparam int IDW    = $clog2(NUM_LINES + 1);
    localparam int MAXC   = (ENTRY_CYC > EXIT_CYC) ?
                            ((ENTRY_CYC > CHAIN_CYC) ? ENTRY_CYC : CHAIN_CYC) :
                            ((EXIT_CYC > CHAIN_CYC) ? EXIT_CYC : CHAIN_CYC);
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [IDW-1:0]   NMI_ID     = IDW'(NUM_LINES);
    localparam logic [KEY_W-1:0] THREAD_KEY = {2'b10, {PRIO_W{1'b0}}};

    typedef struct packed {
        ctl_state_e                       st;
        logic [CNT_W-1:0]                 cnt;
        logic [IDW-1:0]                   tgt;
        logic [KEY_W-1:0]                 tkey;
        logic [NUM_LINES-1:0]             en;
        logic [NUM_LINES-1:0]             pend;
        logic [NUM_LINES-1:0]             act;
        logic                             nmi_pend;
        logic                             nmi_act;
        logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic [NUM_LINES-1:0] id_mask(input logic [IDW-1:0] id);
        logic [NUM_LINES-1:0] m;
        for (int i = 0; i < NUM_LINES; i++) m[i] = (id == IDW'(i));
        return m;
    endfunction

    logic [IDW-1:0]   top_id, win_id, push_id;
    logic             stk_empty, stk_full, push, pop;
    logic [KEY_W-1:0] lvl_now, lvl_after, win_key, thr;
    logic             hit, ret_ok;

    irq_active_stack #(.DEPTH(NUM_LINES + 1), .IDW(IDW)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .push_id(push_id),
        .top_id(top_id), .empty(stk_empty), .full(stk_full)
    );

    irq_level_min #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_lvl_now (
        .act_lines(ctl_q.act), .act_nmi(ctl_q.nmi_act), .prio(ctl_q.prio),
        .level(lvl_now)
    );

    // Level left once the current exception retires.
    irq_level_min #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_lvl_after (
        .act_lines(ctl_q.act & ~id_mask(top_id)),
        .act_nmi(ctl_q.nmi_act && (top_id != NMI_ID)),
        .prio(ctl_q.prio), .level(lvl_after)
    );

    irq_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
        .cand_lines(ctl_q.pend & ctl_q.en), .cand_nmi(ctl_q.nmi_pend),
        .prio(ctl_q.prio), .best_id(win_id), .best_key(win_key)
    );

    assign ret_ok = (ctl_q.st == ST_RUN) && exc_return && !stk_empty;
    assign thr    = ret_ok ? lvl_after : lvl_now;
    assign hit    = (win_key < thr);

    always_comb begin
        ctl_d   = ctl_q;
        push    = 1'b0;
        pop     = 1'b0;
        if (reg_wr) begin
            case (reg_sel)
                SEL_EN_SET:   ctl_d.en   = ctl_q.en | reg_wdata[NUM_LINES-1:0];
                SEL_EN_CLR:   ctl_d.en   = ctl_q.en & ~reg_wdata[NUM_LINES-1:0];
                SEL_PEND_SET: ctl_d.pend = ctl_q.pend | reg_wdata[NUM_LINES-1:0];
                SEL_PEND_CLR: ctl_d.pend = ctl_q.pend & ~reg_wdata[NUM_LINES-1:0];
                SEL_PRIO: begin
                    for (int i = 0; i < NUM_LINES; i++) begin
                        if (reg_idx == IDXW'(i)) ctl_d.prio[i] = reg_wdata[PRIO_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        unique case (ctl_q.st)
            ST_RUN: begin
                if (ret_ok) begin
                    pop = 1'b1;
                    ctl_d.act = ctl_q.act & ~id_mask(top_id);
                    if (top_id == NMI_ID) ctl_d.nmi_act = 1'b0;
                    if (hit) begin
                        ctl_d.st   = ST_CHAIN;
                        ctl_d.cnt  = CNT_W'(CHAIN_CYC - 1);
                        ctl_d.tgt  = win_id;
                        ctl_d.tkey = win_key;
                    end else if (lvl_after == THREAD_KEY) begin
                        ctl_d.st  = ST_EXIT;
                        ctl_d.cnt = CNT_W'(EXIT_CYC - 1);
                    end
                end else if (hit) begin
                    ctl_d.st   = ST_ENTRY;
                    ctl_d.cnt  = CNT_W'(ENTRY_CYC - 1);
                    ctl_d.tgt  = win_id;
                    ctl_d.tkey = win_key;
                end
            end
            ST_ENTRY, ST_CHAIN: begin
                if (hit && (win_key < ctl_q.tkey)) begin
                    ctl_d.tgt  = win_id;
                    ctl_d.tkey = win_key;
                end
                if (ctl_q.cnt == '0) begin
                    push       = 1'b1;
                    ctl_d.st   = ST_RUN;
                end else begin
                    ctl_d.cnt  = ctl_q.cnt - 1'b1;
                end
            end
            ST_EXIT: begin
                if (hit) begin
                    ctl_d.st   = ST_CHAIN;
                    ctl_d.cnt  = CNT_W'(CHAIN_CYC - 1);
                    ctl_d.tgt  = win_id;
                    ctl_d.tkey = win_key;
                end else if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_RUN;
                end else begin
                    ctl_d.cnt  = ctl_q.cnt - 1'b1;
                end
            end
        endcase

        push_id = ctl_d.tgt;
        if (push) begin
            ctl_d.act  = ctl_d.act | id_mask(ctl_d.tgt);
            ctl_d.pend = ctl_d.pend & ~id_mask(ctl_d.tgt);
            if (ctl_d.tgt == NMI_ID) begin
                ctl_d.nmi_act  = 1'b1;
                ctl_d.nmi_pend = 1'b0;
            end
        end
        ctl_d.pend = ctl_d.pend | irq_in;
        if (nmi_req) ctl_d.nmi_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_RUN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_EN_SET, SEL_EN_CLR:     reg_rdata = DW'(ctl_q.en);
            SEL_PEND_SET, SEL_PEND_CLR: reg_rdata = DW'(ctl_q.pend);
            SEL_PRIO: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (reg_idx == IDXW'(i)) reg_rdata = DW'(ctl_q.prio[i]);
                end
            end
            SEL_ACTIVE:   reg_rdata = DW'(ctl_q.act);
            SEL_NMI_STAT: reg_rdata = DW'({ctl_q.nmi_act, ctl_q.nmi_pend});
            default:      reg_rdata = '0;
        endcase
    end

    assign core_busy   = (ctl_q.st != ST_RUN);
    assign handler_run = (ctl_q.st == ST_RUN) && !stk_empty;

    always_comb begin
        if (stk_empty)            vector = '0;
        else if (top_id == NMI_ID) vector = VEC_W'(VEC_NMI);
        else                      vector = VEC_W'(VEC_LINE_BASE) + VEC_W'(top_id);
    end

    // Save interval is not cut short.
    assert_entry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ENTRY && ctl_q.cnt != '0) |=> (ctl_q.st == ST_ENTRY));
    assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CHAIN && ctl_q.cnt != '0) |=> (ctl_q.st == ST_CHAIN));
    assert_exit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EXIT && ctl_q.cnt != '0 && !hit) |=> (ctl_q.st == ST_EXIT));
    // Each newly taken exception raises the execution level.
    assert_level_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (lvl_now < $past(lvl_now)));
    // Stack occupancy and active set agree.
    assert_stack_vs_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty == (lvl_now == THREAD_KEY));
    assert_nmi_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && ctl_q.nmi_pend && !ctl_q.nmi_act) |=> (ctl_q.st != ST_RUN));
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
    localparam int N    = 6;
    localparam int PW   = 8;
    localparam int IXW  = $clog2(N);
    localparam int DW   = (N > PW) ? N : PW;
    localparam int VW   = $clog2(N + 17);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [IXW-1:0] reg_idx = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          nmi_req = 1'b0;
    logic          exc_return = 1'b0;
    logic          core_busy, handler_run;
    logic [VW-1:0] vector;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl #(.NUM_LINES(N), .PRIO_W(PW), .ENTRY_CYC(12), .CHAIN_CYC(6),
                    .EXIT_CYC(12)) u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .nmi_req(nmi_req), .exc_return(exc_return),
        .core_busy(core_busy), .handler_run(handler_run), .vector(vector)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int idx, input int data);
        reg_wr = 1'b1; reg_sel = 3'(sel); reg_idx = IXW'(idx); reg_wdata = DW'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int sel, input int idx, output int data);
        reg_sel = 3'(sel); reg_idx = IXW'(idx);
        #1 data = int'(reg_rdata);
    endtask

    task automatic ret();
        exc_return = 1'b1;
        @(negedge clk);
        exc_return = 1'b0;
    endtask

    // Counts busy cycles from the current sample until busy drops.
    task automatic busy_len(output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            if (core_busy) n++;
            else if (n > 0) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_run();
        for (int k = 0; k < 100; k++) begin
            if (handler_run) break;
            @(negedge clk);
        end
    endtask

    function automatic int best(input int mask, input int pr[N]);
        int b = -1;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (b < 0 || pr[i] < pr[b])) b = i;
        end
        return b;
    endfunction

    initial begin
        int v, n, mask, e;
        int pr[N];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R6 reset vector", int'(vector), 0);
        check("R6 reset busy", int'(core_busy), 0);
        rd(0, 0, v); check("R1 reset enables", v, 0);
        rd(5, 0, v); check("R3 reset active", v, 0);

        // R1 register access
        wr(0, 0, 6'b101101); rd(0, 0, v); check("R1 enable set", v, 6'b101101);
        wr(1, 0, 6'b000101); rd(1, 0, v); check("R1 enable clear", v, 6'b101000);
        wr(2, 0, 6'b000010); rd(2, 0, v); check("R1 pending set", v, 6'b000010);
        repeat (20) @(negedge clk);
        check("R2 disabled line not taken", int'(handler_run), 0);
        check("R2 disabled line no busy", int'(core_busy), 0);
        wr(3, 0, 6'b000010); rd(3, 0, v); check("R1 pending clear", v, 0);

        // R4 priority fields
        wr(4, 3, 8'hA5); rd(4, 3, v); check("R4 priority readback", v, 8'hA5);
        wr(4, 0, 1); wr(4, 1, 5); wr(4, 2, 5); wr(4, 3, 2); wr(4, 4, 5); wr(4, 5, 9);
        rd(4, 5, v); check("R4 priority line5", v, 9);
        wr(0, 0, 6'b111111);

        // Entry from thread
        wr(2, 0, 6'b000100);
        busy_len(n); check("R6 entry length", n, 12);
        check("R6 vector line2", int'(vector), 18);
        check("R6 handler running", int'(handler_run), 1);
        rd(2, 0, v); check("R11 pending cleared on take", v, 0);
        rd(5, 0, v); check("R3 active line2", v, 6'b000100);

        // Equal level waits
        wr(2, 0, 6'b010000);
        repeat (20) @(negedge clk);
        check("R2 equal level no preempt", int'(vector), 18);
        check("R2 equal level no busy", int'(core_busy), 0);

        // Preemption
        wr(2, 0, 6'b001000);
        busy_len(n); check("R6 preempt entry length", n, 12);
        check("R6 vector line3", int'(vector), 19);
        rd(5, 0, v); check("R3 preempted stays active", v, 6'b001100);
        wr(5, 0, 0); rd(5, 0, v); check("R3 active write ignored", v, 6'b001100);

        // Re-pend while active
        wr(2, 0, 6'b001000); rd(2, 0, v); check("R12 re-pend held", v, 6'b011000);
        repeat (10) @(negedge clk);
        check("R12 no self preempt", int'(core_busy), 0);
        ret();
        busy_len(n); check("R7 chain length", n, 6);
        check("R12 re-pended line retaken", int'(vector), 19);
        ret();
        check("R8 nested resume no busy", int'(core_busy), 0);
        check("R8 nested resume vector", int'(vector), 18);
        rd(5, 0, v); check("R3 active after return", v, 6'b000100);
        ret();
        busy_len(n); check("R7 chain to line4", n, 6);
        check("R7 vector line4", int'(vector), 20);
        ret();
        busy_len(n); check("R8 final restore length", n, 12);
        check("R8 thread vector", int'(vector), 0);

        // Late arrival
        wr(2, 0, 6'b100000);
        n = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (core_busy) n++;
        end
        wr(2, 0, 6'b000001);
        busy_len(e); check("R9 save not lengthened", n + e, 12);
        check("R9 urgent entered first", int'(vector), 16);
        rd(2, 0, v); check("R9 displaced still pending", v, 6'b100000);
        ret();
        busy_len(n); check("R9 displaced chains", n, 6);
        check("R9 vector line5", int'(vector), 21);
        ret(); busy_len(n);

        // Ties
        wr(2, 0, 6'b010010);
        busy_len(n);
        check("R10 lowest line wins", int'(vector), 17);
        ret(); busy_len(n);
        check("R10 second of tie", int'(vector), 20);
        ret(); busy_len(n);

        // Non-maskable
        wr(1, 0, 6'b111111);
        nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
        busy_len(n); check("R5 nmi entry", n, 12);
        check("R5 nmi vector", int'(vector), 2);
        rd(6, 0, v); check("R5 nmi status", v, 2);
        ret(); busy_len(n);
        check("R8 nmi return thread", int'(vector), 0);
        wr(4, 0, 0); wr(0, 0, 6'b000001); wr(2, 0, 6'b000001);
        busy_len(n); check("R4 level zero taken", int'(vector), 16);
        nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
        busy_len(n); check("R5 nmi preempts level zero", int'(vector), 2);
        ret();
        check("R8 resume after nmi", int'(vector), 16);
        ret(); busy_len(n);

        // Hardware request input
        wr(0, 0, 6'b001000);
        irq_in = 6'b001000; @(negedge clk); irq_in = '0;
        busy_len(n); check("R11 irq_in taken", int'(vector), 19);
        rd(2, 0, v); check("R11 irq_in pending cleared", v, 0);
        ret(); busy_len(n);

        // Random request sets
        process::self().srandom(32'd2024);
        wr(0, 0, 6'b111111);
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < N; i++) begin
                pr[i] = $urandom_range(0, 15);
                wr(4, i, pr[i]);
            end
            mask = $urandom_range(1, 63);
            wr(2, 0, mask);
            while (mask != 0) begin
                wait_run();
                e = best(mask, pr);
                check("R10 random order", int'(vector), 16 + e);
                mask = mask & ~(1 << e);
                ret();
            end
            busy_len(n);
            check("R8 random end thread", int'(vector), 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule